// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer Bank

This block keeps three interval timers for an 8-bit sound co-processor. Each channel divides the system clock by a fixed power of two, counts the divided ticks against a programmable 8-bit period, and bumps a small 4-bit output counter every time a full period has elapsed. The two slow channels divide by 128. The last channel divides by 16.

The CPU side sees four kinds of strobe per channel. An enable level comes from a control register. A period write strobe shares one data bus with the other channels. A counter read strobe returns the channel's 4-bit value on an 8-bit read bus and clears the counter in the same access. A counter write strobe only clears the counter. Address decoding for the I/O page sits outside this block.

Top module: `tmr_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) disables every channel, sets every stored period to 0 (which means 256), and clears every prescaler, internal count and output counter.
- R2: While enabled, channels 0 and 1 produce a prescaler tick once every 128 clocks and channel 2 once every 16 clocks. The first tick comes at the 128th (or 16th) clock edge after the edge at which the enable was seen rising.
- R3: On each tick the internal count advances. When it would reach the effective period (stored value 0 means 256), it returns to 0 and the 4-bit output counter increments, wrapping from 15 to 0.
- R4: A period write stores `per_wdata` at the clock edge, and only then. The tick at that same edge is judged against the old period. If the internal count already meets or exceeds a smaller new period, the next tick ends the period at once.
- R5: While any `cnt_rd` bit is high, `cnt_rdata[3:0]` shows the output counter of the lowest-numbered strobed channel and `cnt_rdata[7:4]` is 0. With no read strobe, `cnt_rdata` is 0. Every strobed channel's counter clears at the clock edge.
- R6: A `cnt_wr` strobe clears that channel's output counter at the clock edge. It carries no data.
- R7: If a period ends at the same edge as a read or write clear, the read shows the value from before the increment and the counter ends at 1.
- R8: At the edge where a channel's enable is seen going from 0 to 1, its internal count and output counter clear and its prescaler phase restarts.
- R9: While its enable is 0, a channel's prescaler, internal count and output counter do not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_en | input | 3 | Per-channel enable level |
| per_wr | input | 3 | Per-channel period write strobe |
| per_wdata | input | 8 | Period value for write strobes |
| cnt_rd | input | 3 | Per-channel counter read strobe (read clears) |
| cnt_wr | input | 3 | Per-channel counter clear strobe |
| cnt_rdata | output | 8 | Counter read data, upper bits zero |

## Verification
The bench builds the bank with its default parameters: three channels, shifts of 7 and 4, an 8-bit period and a 4-bit counter. The 16-clock channel brings a full 256-tick period and several counter wraps within a few thousand clocks. The 128-clock channels are used to confirm the slower spacing and the shared read bus priority. Directed phases hit the collisions between ends of periods and clears, re-enable restarts and period shrinks below the running count. A random phase then mixes every strobe against the reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Prescale shift for a channel: the last channel runs fast, all others slow.
    function automatic int unsigned chan_shift(input int unsigned idx,
                                               input int unsigned n_ch,
                                               input int unsigned slow_sh,
                                               input int unsigned fast_sh);
        return (idx == n_ch - 1) ? fast_sh : slow_sh;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned SHIFT = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic restart_i,
    output logic tick_o
);

    typedef struct packed {
        logic [SHIFT-1:0] ph;
    } pre_st_t;

    pre_st_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (restart_i) begin
            st_d.ph = '0;
        end else if (en_i) begin
            st_d.ph = st_q.ph + 1'b1;
            tick_o  = &st_q.ph;
        end
        if (rst) begin
            st_d   = '0;
            tick_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int unsigned SHIFT = 7,
    parameter int unsigned PER_W = 8,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             per_wr_i,
    input  logic [PER_W-1:0] per_data_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int unsigned EP_W = PER_W + 1;

    typedef struct packed {
        logic             en;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] icnt;
        logic [CNT_W-1:0] ocnt;
    } ch_st_t;

    ch_st_t          st_q, st_d;
    logic            rise;
    logic            tick;
    logic            wrap;
    logic [EP_W-1:0] eff_per;
    logic [EP_W-1:0] icnt_nxt;

    assign rise = en_i & ~st_q.en;

    tmr_prescale #(.SHIFT(SHIFT)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .restart_i (rise),
        .tick_o    (tick)
    );

    always_comb begin
        st_d     = st_q;
        wrap     = 1'b0;
        eff_per  = (st_q.per == '0) ? {1'b1, {PER_W{1'b0}}} : {1'b0, st_q.per};
        icnt_nxt = {1'b0, st_q.icnt} + 1'b1;
        st_d.en  = en_i;

        if (rise) begin
            st_d.icnt = '0;
            st_d.ocnt = '0;
        end else begin
            if (tick) begin
                if (icnt_nxt >= eff_per) begin
                    st_d.icnt = '0;
                    wrap      = 1'b1;
                end else begin
                    st_d.icnt = icnt_nxt[PER_W-1:0];
                end
            end
            if (clr_i) begin
                st_d.ocnt = CNT_W'(wrap);
            end else begin
                st_d.ocnt = st_q.ocnt + CNT_W'(wrap);
            end
        end

        if (per_wr_i && (per_data_i != st_q.per)) begin
            st_d.per = per_data_i;
        end

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.ocnt;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int unsigned NUM_CH     = 3,
    parameter int unsigned SLOW_SHIFT = 7,
    parameter int unsigned FAST_SHIFT = 4,
    parameter int unsigned PER_W      = 8,
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tmr_en,
    input  logic [NUM_CH-1:0] per_wr,
    input  logic [PER_W-1:0]  per_wdata,
    input  logic [NUM_CH-1:0] cnt_rd,
    input  logic [NUM_CH-1:0] cnt_wr,
    output logic [DATA_W-1:0] cnt_rdata
);

    logic [CNT_W-1:0] cnt_w [NUM_CH];
    logic [CNT_W-1:0] sel_cnt;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int unsigned SH =
            tmr_pkg::chan_shift(g, NUM_CH, SLOW_SHIFT, FAST_SHIFT);

        tmr_channel #(
            .SHIFT (SH),
            .PER_W (PER_W),
            .CNT_W (CNT_W)
        ) u_ch (
            .clk        (clk),
            .rst        (rst),
            .en_i       (tmr_en[g]),
            .per_wr_i   (per_wr[g]),
            .per_data_i (per_wdata),
            .clr_i      (cnt_rd[g] | cnt_wr[g]),
            .cnt_o      (cnt_w[g])
        );
    end

    // Lowest-numbered strobed channel drives the read bus.
    always_comb begin
        sel_cnt = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cnt_rd[i]) begin
                sel_cnt = cnt_w[i];
            end
        end
        cnt_rdata = DATA_W'(sel_cnt);
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] tmr_en,
    input logic [NUM_CH-1:0] cnt_rd,
    input logic [NUM_CH-1:0] cnt_wr,
    input logic [DATA_W-1:0] cnt_rdata
);

    // R5: an idle read bus carries zero
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd == '0) |-> (cnt_rdata == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1) << g;

        // R5: back-to-back reads see at most one new increment
        a_r5_reread_small: assert property (@(posedge clk) disable iff (rst)
            ($past(cnt_rd) == ONE && cnt_rd == ONE) |-> (cnt_rdata <= 1));

        // R9: a disabled channel read twice shows zero the second time
        a_r9_disabled_hold: assert property (@(posedge clk) disable iff (rst)
            (!$past(tmr_en[g]) && !tmr_en[g] && $past(cnt_rd) == ONE && cnt_rd == ONE)
            |-> (cnt_rdata == '0));

        // R6: a clear strobe on a disabled channel leaves zero
        a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
            (!$past(tmr_en[g]) && !tmr_en[g] && $past(cnt_wr[g]) && cnt_rd == ONE)
            |-> (cnt_rdata == '0));

        // R8: just after a rising enable the counter reads zero
        a_r8_enable_clears: assert property (@(posedge clk) disable iff (rst)
            ($past(tmr_en[g]) && !$past(tmr_en[g], 2) && cnt_rd == ONE)
            |-> (cnt_rdata == '0));
    end

endmodule

bind tmr_bank tmr_bank_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tmr_en    (tmr_en),
    .cnt_rd    (cnt_rd),
    .cnt_wr    (cnt_wr),
    .cnt_rdata (cnt_rdata)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] en = '0, pwr = '0, rd = '0, wr = '0;
    logic [7:0] pdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;
    int last_rd = 0;
    bit done = 0;

    // behavioural reference state
    int m_pre [3] = '{0, 0, 0};
    int m_icnt[3] = '{0, 0, 0};
    int m_ocnt[3] = '{0, 0, 0};
    int m_per [3] = '{0, 0, 0};
    bit m_en  [3] = '{0, 0, 0};
    int shift [3] = '{7, 7, 4};

    always #2 clk = ~clk;

    tmr_bank dut (
        .clk       (clk),
        .rst       (rst),
        .tmr_en    (en),
        .per_wr    (pwr),
        .per_wdata (pdata),
        .cnt_rd    (rd),
        .cnt_wr    (wr),
        .cnt_rdata (rdata)
    );

    function automatic int model_rd();
        for (int i = 0; i < 3; i++) if (rd[i]) return m_ocnt[i];
        return 0;
    endfunction

    task automatic model_clk();
        for (int i = 0; i < 3; i++) begin
            int inc = 0;
            int ep;
            if (rst) begin
                m_pre[i] = 0; m_icnt[i] = 0; m_ocnt[i] = 0; m_per[i] = 0; m_en[i] = 0;
                continue;
            end
            if (en[i] && !m_en[i]) begin
                m_pre[i] = 0; m_icnt[i] = 0; m_ocnt[i] = 0;
            end else begin
                if (en[i]) begin
                    m_pre[i]++;
                    if (m_pre[i] == (1 << shift[i])) begin
                        m_pre[i] = 0;
                        m_icnt[i]++;
                        ep = (m_per[i] == 0) ? 256 : m_per[i];
                        if (m_icnt[i] >= ep) begin
                            m_icnt[i] = 0;
                            inc = 1;
                        end
                    end
                end
                if (rd[i] || wr[i]) m_ocnt[i] = inc;
                else                m_ocnt[i] = (m_ocnt[i] + inc) % 16;
            end
            if (pwr[i] && int'(pdata) != m_per[i]) m_per[i] = pdata;
            m_en[i] = en[i];
        end
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, got, exp, $time);
        end
    endtask

    // inputs already set at a falling edge; compare, then advance one clock
    task automatic step(input string req);
        #1;
        last_rd = int'(rdata);
        check(req, last_rd, model_rd());
        @(posedge clk);
        model_clk();
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        rd = '0; wr = '0; pwr = '0;
        for (int k = 0; k < n; k++) step(req);
    endtask

    task automatic rd_ch(input int ch, input string req, input int exp);
        rd = 3'(1 << ch);
        step(req);
        rd = '0;
        check(req, last_rd, exp);
    endtask

    task automatic wr_per(input int ch, input int val, input string req);
        pwr = 3'(1 << ch); pdata = 8'(val);
        step(req);
        pwr = '0;
    endtask

    initial begin
        @(negedge clk);
        idle(3, "R1");
        rst = 1'b0;

        // R1: counters zero after reset
        rd_ch(0, "R1", 0); rd_ch(1, "R1", 0); rd_ch(2, "R1", 0);

        // R1 / R3: default period 256 on the fast channel
        en = 3'b100;
        idle(4096, "R3");
        rd_ch(2, "R7", 0);          // period ends at this edge -> ends at 1
        rd_ch(2, "R7", 1);

        en = 3'b000; idle(1, "R9");
        wr_per(2, 1, "R4");

        // R2: fast channel ticks every 16 clocks
        en = 3'b100;
        idle(80, "R2");
        rd_ch(2, "R2", 4);
        rd_ch(2, "R7", 1);

        // R3: wrap modulo 16
        en = 3'b000; idle(1, "R8");
        en = 3'b100;
        idle(280, "R3");
        rd_ch(2, "R3", 1);

        // R9: disabled channel holds
        en = 3'b000; idle(1, "R9");
        en = 3'b100; idle(40, "R9");
        en = 3'b000; idle(300, "R9");
        rd_ch(2, "R9", 2);
        rd_ch(2, "R9", 0);

        // R6: write strobe clears
        en = 3'b100; idle(40, "R6");
        wr = 3'b100; step("R6"); wr = '0;
        idle(10, "R6");
        rd_ch(2, "R6", 1);

        // R8: re-enable clears and restarts prescaler
        idle(40, "R8");
        en = 3'b000; idle(1, "R8");
        en = 3'b100;
        idle(1, "R8");
        rd_ch(2, "R8", 0);
        idle(14, "R8");
        rd_ch(2, "R8", 0);
        rd_ch(2, "R8", 1);

        // R2: slow channel every 128 clocks
        en = 3'b000; idle(1, "R2");
        wr_per(0, 1, "R2");
        en = 3'b001;
        idle(384, "R2");
        rd_ch(0, "R2", 2);
        rd_ch(0, "R7", 1);

        // R4: shrink period below running count
        en = 3'b000; idle(1, "R4");
        wr_per(2, 10, "R4");
        en = 3'b100;
        idle(96, "R4");
        wr_per(2, 3, "R4");
        idle(16, "R4");
        rd_ch(2, "R4", 1);

        // R5: multiple read strobes, lowest wins
        en = 3'b111; idle(300, "R5");
        rd = 3'b110; step("R5"); rd = '0;
        rd = 3'b111; step("R5"); rd = '0;

        // mixed random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            for (int c = 0; c < 3; c++) begin
                if ($urandom_range(0, 63) == 0) en[c] = ~en[c];
                rd[c]  = ($urandom_range(0, 7) == 0);
                wr[c]  = ($urandom_range(0, 15) == 0);
                pwr[c] = ($urandom_range(0, 31) == 0);
            end
            pdata = 8'($urandom_range(0, 5));
            step("R5");
        end
        idle(2, "R5");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule